// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block turns up to fifteen groups of sixteen general-purpose input lines into one interrupt request. Each line passes through a two-flop synchronizer and is then judged by a trigger selector. One selector serves a set of four neighbouring lines and chooses low level, high level, falling edge, rising edge or both edges. A line that triggers latches a pending bit. Per-line mask bits decide whether a pending line may request service. Software clears pending bits by writing ones to them.

A read-only service word names one pending, unmasked line. Its upper nibble holds the group number, counted from 1, and its lower nibble holds the line inside that group. Group 0 means nothing needs service. An interrupt handler reads the service word, handles the line it names, clears that line's pending bit, and repeats until it reads group 0. The single interrupt output stays high for as long as the service word is non-zero.

Registers sit on a plain 32-bit write/read bus with word addresses. Two consecutive groups share each configuration, mask and pending word.

Top module: `gpio_group_intc`

## Requirements
- R1: After reset every trigger word reads 0, every mask word reads all ones (every line disabled), every pending word reads 0, the service word reads 0 and `irq_out` is low.
- R2: Group number g+1 has internal index g. It lives in the word at byte offset 4*(g/2) of each region: trigger words at 0x00, mask words at 0x20, pending words at 0x40. A line's bit in that word is its global line number (16*g + line) modulo 32. The service word is at 0x60.
- R3: Within a trigger word, the 4-bit field at bits 4*(b/4)+3 : 4*(b/4) sets the mode of the four lines whose bit indices are 4*(b/4) to 4*(b/4)+3, and of no other line.
- R4: Mode 0 (low level) and mode 1 (high level) set the pending bit on every cycle in which the synchronized level is active. A clear written while the level is still active therefore leaves the bit set.
- R5: Mode 2 (falling edge), mode 4 (rising edge) and mode 6 (either edge) set the pending bit once per matching transition of the synchronized input. A clear is not undone while the input stays at a constant level.
- R6: Trigger field values other than 0, 1, 2, 4 and 6 never set a pending bit.
- R7: A mask bit of 1 keeps its line out of the service word and out of `irq_out`. The pending bit still latches and stays readable.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A trigger event in the same cycle as the clear wins. Writes to the service word have no effect.
- R9: The service word holds the group number (1 to NUM_GROUPS) in bits 7:4 and the line number in bits 3:0. Bits 31:8 are zero. It names the lowest-numbered group that has any pending, unmasked line, and within that group the lowest such line. It reads 0 when no pending, unmasked line exists.
- R10: `irq_out` is high exactly when the service word is non-zero.
- R11: A change on `gpio_in` first appears in a pending bit after the third rising clock edge following the change, and not after the second.
- R12: Group 1 reports all sixteen of its lines, 0 to 15, in the service word, both below 8 and from 8 upward.
- R13: Reads from a word that is not mapped (a pair index at or beyond the number of group pairs, an unused region, or a byte address not a multiple of 4) return 0. Writes to such a word change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | NUM_GROUPS*16 | Raw input lines; bit 16*g+l is line l of group g+1 |
| bus_wr_en | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The first set of patterns holds inputs steady and changes them one at a time. This tells the level modes apart from the edge modes: after a clear, a held level sets the pending bit again, while a held edge-mode input does not. The two-flop latency is probed on the cycles just before and just after the bit appears. Simultaneous pending lines in group 1 (below 8 and from 8 upward) and in a higher group, followed by masking the winner, separate the group priority from the line priority and from the mask gating. Paired input transitions on falling, both-edge and undefined fields tell which transitions each code counts. A behavioural model compares the service word and the interrupt output on every clock.

// File: rtl/gpio_group_intc_pkg.sv
package gpio_group_intc_pkg;

    localparam int LINES_PER_GROUP = 16;
    localparam int LINES_PER_SEL   = 4;
    localparam int SEL_W           = 4;
    localparam int SELS_PER_GROUP  = LINES_PER_GROUP / LINES_PER_SEL;
    localparam int GROUP_CFG_W     = SELS_PER_GROUP * SEL_W;
    localparam int NUM_W           = 4;
    localparam int BUS_W           = 32;
    localparam int ADDR_W          = 8;
    localparam int GROUPS_PER_WORD = BUS_W / LINES_PER_GROUP;

    typedef enum logic [SEL_W-1:0] {
        TRIG_LOW  = 4'd0,
        TRIG_HIGH = 4'd1,
        TRIG_FALL = 4'd2,
        TRIG_RISE = 4'd4,
        TRIG_BOTH = 4'd6
    } trig_mode_e;

    typedef enum logic [2:0] {
        RGN_TRIG = 3'd0,
        RGN_MASK = 3'd1,
        RGN_PEND = 3'd2,
        RGN_SVC  = 3'd3
    } reg_region_e;

    typedef struct packed {
        logic [NUM_W-1:0] group;
        logic [NUM_W-1:0] line;
    } svc_code_t;

    // Decide whether one line fires this cycle from its mode,
    // its current synchronized level and the level one cycle earlier.
    function automatic logic trig_hit(input logic [SEL_W-1:0] code,
                                      input logic now_v,
                                      input logic was_v);
        logic hit;
        case (code)
            TRIG_LOW:  hit = !now_v;
            TRIG_HIGH: hit = now_v;
            TRIG_FALL: hit = was_v && !now_v;
            TRIG_RISE: hit = !was_v && now_v;
            TRIG_BOTH: hit = was_v != now_v;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gic_sync_edge.sv
module gic_sync_edge #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] prv
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign lvl = sync_q;
    assign prv = last_q;

endmodule

// File: rtl/gic_group_slice.sv
module gic_group_slice
    import gpio_group_intc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LINES_PER_GROUP-1:0] lvl,
    input  logic [LINES_PER_GROUP-1:0] prv,
    input  logic                       cfg_we,
    input  logic                       mask_we,
    input  logic                       clr_we,
    input  logic [LINES_PER_GROUP-1:0] wdata,
    output logic [GROUP_CFG_W-1:0]     cfg_q,
    output logic [LINES_PER_GROUP-1:0] mask_q,
    output logic [LINES_PER_GROUP-1:0] pend_q
);

    logic [LINES_PER_GROUP-1:0] set_vec;
    logic [LINES_PER_GROUP-1:0] clr_vec;

    for (genvar l = 0; l < LINES_PER_GROUP; l++) begin : g_line
        localparam int SEL = l / LINES_PER_SEL;
        assign set_vec[l] = trig_hit(cfg_q[SEL*SEL_W +: SEL_W], lvl[l], prv[l]);
    end

    assign clr_vec = clr_we ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            mask_q <= '1;
            pend_q <= '0;
        end else begin
            if (cfg_we) begin
                cfg_q <= wdata;
            end
            if (mask_we) begin
                mask_q <= wdata;
            end
            pend_q <= (pend_q & ~clr_vec) | set_vec;
        end
    end

    // R8
    pend_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((set_vec & wdata) == '0)) |=> ((pend_q & $past(wdata)) == '0));

    // R8
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((~pend_q & $past(pend_q)) == '0));

endmodule

// File: rtl/gic_service_pick.sv
module gic_service_pick
    import gpio_group_intc_pkg::*;
#(
    parameter int NUM_GROUPS = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_GROUPS*LINES_PER_GROUP-1:0] act,
    output svc_code_t                             svc
);

    localparam int TOT   = NUM_GROUPS * LINES_PER_GROUP;
    localparam int IDX_W = $clog2(TOT);

    logic [NUM_GROUPS-1:0]      grp_any;
    logic [NUM_W-1:0]           grp_sel;
    logic [LINES_PER_GROUP-1:0] row;
    logic [NUM_W-1:0]           line_sel;
    logic                       valid;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_any
        assign grp_any[g] = |act[g*LINES_PER_GROUP +: LINES_PER_GROUP];
    end

    // First level: lowest group holding any live line.
    always_comb begin
        grp_sel = '0;
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if (grp_any[g]) begin
                grp_sel = NUM_W'(g);
            end
        end
    end

    assign valid = |grp_any;
    assign row   = act[grp_sel*LINES_PER_GROUP +: LINES_PER_GROUP];

    // Second level: lowest live line inside the chosen group.
    always_comb begin
        line_sel = '0;
        for (int l = LINES_PER_GROUP - 1; l >= 0; l--) begin
            if (row[l]) begin
                line_sel = NUM_W'(l);
            end
        end
    end

    always_comb begin
        if (valid) begin
            svc.group = grp_sel + NUM_W'(1);
            svc.line  = line_sel;
        end else begin
            svc.group = '0;
            svc.line  = '0;
        end
    end

    logic [IDX_W-1:0] chk_idx;
    logic [TOT-1:0]   below_hit;

    assign chk_idx   = IDX_W'((int'(svc.group) - 1) * LINES_PER_GROUP + int'(svc.line));
    assign below_hit = (TOT'(1) << chk_idx) - TOT'(1);

    // R9
    svc_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc.group != '0) |-> act[chk_idx]);

    // R9
    svc_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc.group != '0) |-> ((act & below_hit) == '0));

    // R9
    svc_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> (svc == '0));

endmodule

// File: rtl/gpio_group_intc.sv
module gpio_group_intc
    import gpio_group_intc_pkg::*;
#(
    parameter int NUM_GROUPS = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_GROUPS*LINES_PER_GROUP-1:0] gpio_in,
    input  logic                                  bus_wr_en,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic [BUS_W-1:0]                      bus_wdata,
    output logic [BUS_W-1:0]                      bus_rdata,
    output logic                                  irq_out
);

    localparam int TOT       = NUM_GROUPS * LINES_PER_GROUP;
    localparam int NUM_PAIRS = (NUM_GROUPS + GROUPS_PER_WORD - 1) / GROUPS_PER_WORD;

    reg_region_e region;
    logic [2:0]  pair;
    logic        aligned;

    assign region  = reg_region_e'(bus_addr[7:5]);
    assign pair    = bus_addr[4:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    logic [TOT-1:0] lvl_all;
    logic [TOT-1:0] prv_all;
    logic [TOT-1:0] act_all;

    logic [GROUP_CFG_W-1:0]     cfg_g  [NUM_GROUPS];
    logic [LINES_PER_GROUP-1:0] mask_g [NUM_GROUPS];
    logic [LINES_PER_GROUP-1:0] pend_g [NUM_GROUPS];

    gic_sync_edge #(
        .WIDTH (TOT)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (gpio_in),
        .lvl   (lvl_all),
        .prv   (prv_all)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int P = g / GROUPS_PER_WORD;
        localparam int H = g % GROUPS_PER_WORD;

        logic hit;
        assign hit = bus_wr_en && aligned && (pair == 3'(P));

        gic_group_slice u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl     (lvl_all[g*LINES_PER_GROUP +: LINES_PER_GROUP]),
            .prv     (prv_all[g*LINES_PER_GROUP +: LINES_PER_GROUP]),
            .cfg_we  (hit && (region == RGN_TRIG)),
            .mask_we (hit && (region == RGN_MASK)),
            .clr_we  (hit && (region == RGN_PEND)),
            .wdata   (bus_wdata[H*LINES_PER_GROUP +: LINES_PER_GROUP]),
            .cfg_q   (cfg_g[g]),
            .mask_q  (mask_g[g]),
            .pend_q  (pend_g[g])
        );

        assign act_all[g*LINES_PER_GROUP +: LINES_PER_GROUP] = pend_g[g] & ~mask_g[g];
    end

    svc_code_t svc;

    gic_service_pick #(
        .NUM_GROUPS (NUM_GROUPS)
    ) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act_all),
        .svc   (svc)
    );

    assign irq_out = (svc.group != '0);

    // Read mux: pair words are assembled from the two groups they hold.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (region)
                RGN_TRIG: begin
                    for (int g = 0; g < NUM_GROUPS; g++) begin
                        if (int'(pair) == g / GROUPS_PER_WORD) begin
                            bus_rdata[(g % GROUPS_PER_WORD)*LINES_PER_GROUP +: LINES_PER_GROUP] = cfg_g[g];
                        end
                    end
                end
                RGN_MASK: begin
                    for (int g = 0; g < NUM_GROUPS; g++) begin
                        if (int'(pair) == g / GROUPS_PER_WORD) begin
                            bus_rdata[(g % GROUPS_PER_WORD)*LINES_PER_GROUP +: LINES_PER_GROUP] = mask_g[g];
                        end
                    end
                end
                RGN_PEND: begin
                    for (int g = 0; g < NUM_GROUPS; g++) begin
                        if (int'(pair) == g / GROUPS_PER_WORD) begin
                            bus_rdata[(g % GROUPS_PER_WORD)*LINES_PER_GROUP +: LINES_PER_GROUP] = pend_g[g];
                        end
                    end
                end
                RGN_SVC: begin
                    if (pair == 3'd0) begin
                        bus_rdata = BUS_W'(svc);
                    end
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    // R7
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_all == '0) |-> !irq_out);

    // R13
    pair_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned && (region == RGN_PEND) && (int'(pair) >= NUM_PAIRS)) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_gpio_group_intc.sv
module sim_gpio_group_intc;

    localparam int CLK_NS = 10;
    localparam int NG     = 8;
    localparam int TOT    = NG * 16;
    localparam logic [7:0] A_TRIG = 8'h00;
    localparam logic [7:0] A_MASK = 8'h20;
    localparam logic [7:0] A_PEND = 8'h40;
    localparam logic [7:0] A_SVC  = 8'h60;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [TOT-1:0] gpio_in = '0;
    logic           bus_wr_en = 1'b0;
    logic [7:0]     bus_addr = 8'h60;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    gpio_group_intc #(.NUM_GROUPS(NG)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .gpio_in   (gpio_in),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // ---------------- behavioural reference model ----------------
    bit [TOT-1:0] m_meta = '0, m_sync = '0, m_last = '0, m_pend = '0;
    bit [TOT-1:0] m_mask = '1;
    bit [TOT-1:0] m_ev;
    bit [3:0]     m_code [TOT/4];
    int           m_g;

    initial begin
        for (int i = 0; i < TOT/4; i++) m_code[i] = 4'd0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_meta = '0; m_sync = '0; m_last = '0; m_pend = '0; m_mask = '1;
            for (int i = 0; i < TOT/4; i++) m_code[i] = 4'd0;
        end else begin
            for (int i = 0; i < TOT; i++) begin
                case (m_code[i/4])
                    4'd0: m_ev[i] = !m_sync[i];
                    4'd1: m_ev[i] = m_sync[i];
                    4'd2: m_ev[i] = m_last[i] && !m_sync[i];
                    4'd4: m_ev[i] = !m_last[i] && m_sync[i];
                    4'd6: m_ev[i] = m_last[i] != m_sync[i];
                    default: m_ev[i] = 1'b0;
                endcase
            end
            if (bus_wr_en && bus_addr[1:0] == 2'b00) begin
                for (int j = 0; j < 32; j++) begin
                    m_g = int'(bus_addr[4:2]) * 32 + j;
                    if (m_g < TOT) begin
                        case (bus_addr[7:5])
                            3'd0: if (j % 4 == 0) m_code[m_g/4] = bus_wdata[j +: 4];
                            3'd1: m_mask[m_g] = bus_wdata[j];
                            3'd2: if (bus_wdata[j]) m_pend[m_g] = 1'b0;
                            default: ;
                        endcase
                    end
                end
            end
            m_pend = m_pend | m_ev;
            m_last = m_sync;
            m_sync = m_meta;
            m_meta = gpio_in;
        end
    end

    function automatic logic [31:0] model_svc();
        for (int g = 0; g < NG; g++) begin
            for (int l = 0; l < 16; l++) begin
                if (m_pend[g*16+l] && !m_mask[g*16+l]) return {24'd0, 4'(g+1), 4'(l)};
            end
        end
        return 32'd0;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Compared on every clock, away from the edge.
    always @(posedge clk) begin
        #(CLK_NS/4);
        if (rst_n && !done) begin
            check(irq_out == (model_svc() != 0), "R10 irq vs model", 32'(irq_out), 32'(model_svc() != 0));
            if (!bus_wr_en && bus_addr == A_SVC)
                check(bus_rdata == model_svc(), "R9 service vs model", bus_rdata, model_svc());
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_addr = A_SVC;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(bus_rdata === exp, tag, bus_rdata, exp);
        bus_addr = A_SVC;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_TRIG, 32'h0, "R1 trigger reset");
        rd(A_MASK + 8'h0C, 32'hFFFF_FFFF, "R1 mask reset");
        rd(A_PEND, 32'h0, "R1 pending reset");
        rd(A_SVC, 32'h0, "R1 service reset");
        check(irq_out == 1'b0, "R1 irq reset", 32'(irq_out), 32'h0);

        // Rising-edge mode everywhere, then clear and unmask.
        for (int p = 0; p < 4; p++) wr(A_TRIG + 8'(4*p), 32'h4444_4444);
        for (int p = 0; p < 4; p++) wr(A_PEND + 8'(4*p), 32'hFFFF_FFFF);
        idle(1);
        for (int p = 0; p < 4; p++) rd(A_PEND + 8'(4*p), 32'h0, "R8 clear all");
        for (int p = 0; p < 4; p++) wr(A_MASK + 8'(4*p), 32'h0);
        rd(A_SVC, 32'h0, "R9 none pending");

        // R11 latency, R2 placement, R5 rising edge
        gpio_in[37] = 1'b1;
        idle(2);
        rd(A_PEND + 8'h04, 32'h0, "R11 not after second edge");
        idle(1);
        rd(A_PEND + 8'h04, 32'h20, "R11 after third edge");
        rd(A_PEND + 8'h04, 32'h20, "R2 line 37 at pair1 bit5");
        rd(A_SVC, 32'h35, "R9 group3 line5");
        check(irq_out == 1'b1, "R10 irq high", 32'(irq_out), 32'h1);
        wr(A_PEND + 8'h04, 32'h20);
        idle(2);
        rd(A_PEND + 8'h04, 32'h0, "R5 one event per rise");
        gpio_in[37] = 1'b0;
        idle(4);
        rd(A_PEND + 8'h04, 32'h0, "R5 fall ignored in rise mode");

        // R12 both halves of group 1, R9 priority
        gpio_in[3] = 1'b1; gpio_in[12] = 1'b1;
        idle(4);
        rd(A_PEND, 32'h0000_1008, "R12 group1 lines 3 and 12");
        rd(A_SVC, 32'h13, "R9 lowest line");
        wr(A_PEND, 32'h8);
        rd(A_SVC, 32'h1C, "R12 upper half line 12");
        gpio_in[37] = 1'b1;
        idle(4);
        rd(A_SVC, 32'h1C, "R9 lowest group wins");

        // R7 masking
        wr(A_MASK, 32'h0000_1000);
        rd(A_SVC, 32'h35, "R7 masked line skipped");
        rd(A_PEND, 32'h0000_1000, "R7 pending kept under mask");
        wr(A_MASK + 8'h04, 32'h20);
        rd(A_SVC, 32'h0, "R7 all masked");
        check(irq_out == 1'b0, "R7 irq low when masked", 32'(irq_out), 32'h0);
        wr(A_PEND, 32'hFFFF_FFFF);
        wr(A_PEND + 8'h04, 32'hFFFF_FFFF);
        wr(A_MASK, 32'h0);
        wr(A_MASK + 8'h04, 32'h0);
        rd(A_SVC, 32'h0, "R8 cleared");

        // R4 high level
        wr(A_TRIG + 8'h08, 32'h4444_4441);
        gpio_in[65] = 1'b1;
        idle(4);
        rd(A_PEND + 8'h08, 32'h2, "R4 high level sets");
        rd(A_SVC, 32'h51, "R4 group5 line1");
        wr(A_PEND + 8'h08, 32'h2);
        rd(A_PEND + 8'h08, 32'h2, "R4 level re-sets after clear");
        gpio_in[65] = 1'b0;
        idle(4);
        wr(A_PEND + 8'h08, 32'h2);
        idle(1);
        rd(A_PEND + 8'h08, 32'h0, "R4 clear sticks once level gone");

        // R4 low level on one selector, R3 four lines per selector
        wr(A_TRIG + 8'h08, 32'h4404_4444);
        idle(2);
        rd(A_PEND + 8'h08, 32'h00F0_0000, "R3 selector5 covers lines 84..87");
        rd(A_SVC, 32'h64, "R4 low level group6 line4");
        for (int i = 84; i < 88; i++) gpio_in[i] = 1'b1;
        idle(4);
        wr(A_PEND + 8'h08, 32'hFFFF_FFFF);
        idle(1);
        rd(A_PEND + 8'h08, 32'h0, "R4 low level released");

        // R5 falling / both, R6 undefined code
        wr(A_TRIG + 8'h0C, 32'h4444_4362);
        gpio_in[96] = 1'b1; gpio_in[100] = 1'b1; gpio_in[104] = 1'b1;
        idle(4);
        rd(A_PEND + 8'h0C, 32'h10, "R5 both-edge rise only");
        wr(A_PEND + 8'h0C, 32'hFFFF_FFFF);
        gpio_in[96] = 1'b0; gpio_in[100] = 1'b0; gpio_in[104] = 1'b0;
        idle(4);
        rd(A_PEND + 8'h0C, 32'h11, "R5 falling and both on fall");
        rd(A_SVC, 32'h70, "R9 group7 line0");
        gpio_in[104] = 1'b1;
        idle(4);
        rd(A_PEND + 8'h0C, 32'h11, "R6 undefined code never sets");

        // R8 write side effects, R13 unmapped words
        wr(A_SVC, 32'hFFFF_FFFF);
        rd(A_SVC, 32'h70, "R8 service write ignored");
        wr(A_PEND + 8'h0C, 32'h0);
        rd(A_PEND + 8'h0C, 32'h11, "R8 zero write keeps pending");
        wr(A_TRIG + 8'h10, 32'hFFFF_FFFF);
        rd(A_TRIG + 8'h10, 32'h0, "R13 pair beyond range");
        rd(8'h80, 32'h0, "R13 unused region");
        wr(A_TRIG + 8'h01, 32'h0);
        rd(A_TRIG + 8'h01, 32'h0, "R13 unaligned read");
        rd(A_TRIG, 32'h4444_4444, "R13 unaligned write ignored");

        wr(A_PEND + 8'h0C, 32'hFFFF_FFFF);
        idle(1);
        rd(A_SVC, 32'h0, "R10 service empty");
        check(irq_out == 1'b0, "R10 irq low at end", 32'(irq_out), 32'h0);

        idle(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule